// File: doc/BRIEF.md
# Serial Converter Sampling Controller

This block is the host-side master for an 8-bit serial converter that powers itself down after each conversion. A sample request from the user side starts one complete sequence. The controller drives the start line high so the device wakes up, and keeps it high for a power-up interval. It then lowers the line, which starts the conversion. It waits out the worst-case conversion time with the line held low. Next it generates eight serial clock pulses and collects one data bit per pulse. Finally it presents the byte together with a one-cycle valid strobe.

All intervals are parameters counted in system clock cycles. The start line stays low after the read, so the device sleeps until the next request.

The state machine has six named states:
- IDLE: ready is high and every pin is low.
- POWERUP: the start line is high.
- CONVERT: the start line is low and the controller waits for the conversion to finish.
- CLK_HI and CLK_LO: the two halves of each serial clock period.
- DONE: the valid strobe is high.

The transitions are named as follows:
- IDLE→POWERUP on an accepted request.
- POWERUP→CONVERT when the power-up timer expires.
- CONVERT→CLK_HI when the conversion timer expires.
- CLK_HI→CLK_LO on a falling clock edge that samples a bit.
- CLK_LO→CLK_HI on the next rising clock edge.
- CLK_HI→DONE on the eighth falling edge.
- DONE→IDLE unconditionally.

Top module: `adc_sample_ctrl`

## Requirements
- R1: After reset, ready_o is 1 and start_o, sclk_o and valid_o are 0.
- R2: When a request is accepted in IDLE, start_o goes high on that clock edge and stays high for exactly PWRUP_CYC cycles.
- R3: The first rising edge of sclk_o comes exactly CONV_CYC cycles after start_o falls, so the device has finished the current conversion before any bit is read.
- R4: Exactly eight sclk_o pulses are issued per request. Each pulse is high for HALF_CYC cycles, successive pulses are separated by HALF_CYC low cycles, and sclk_o idles low.
- R5: data_o is assembled MSB first. Each bit is taken from sdata_i on a falling sclk_o edge, and data_o changes only on such an edge. At the valid strobe, data_o equals the byte the device converted.
- R6: start_o rises exactly once per transaction and never between its fall and the valid strobe. A request held high while the controller is busy has no further effect.
- R7: ready_o is 0 from the accepted request up to and including the valid cycle. valid_o lasts exactly one cycle, and ready_o returns to 1 in the following cycle.
- R8: start_o is low when valid_o is asserted and remains low until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Sample request, accepted while ready_o is high |
| ready_o | output | 1 | Controller idle and able to accept a request |
| start_o | output | 1 | Converter start / power-up line |
| sclk_o | output | 1 | Generated serial clock, idles low |
| sdata_i | input | 1 | Serial data from the converter |
| data_o | output | 8 | Received sample byte |
| valid_o | output | 1 | One-cycle strobe marking data_o as the new sample |

## Verification
The hardest case to reach from the ports is a read that starts before the device has latched the new result, because that returns the previous sample. A correct controller never produces this case on its own.

The bench drives a device model that latches each new value only CONV_CYC cycles after the start line falls, and keeps a different older value until then. Any early serial clock therefore shows up as a mismatch in the data byte. The bench also holds the request high across whole transactions, so an illegal second rising edge on the start line mid-read would be caught.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_POWERUP = 3'd1,
        S_CONVERT = 3'd2,
        S_CLK_HI  = 3'd3,
        S_CLK_LO  = 3'd4,
        S_DONE    = 3'd5
    } ctrl_state_t;

endpackage

// File: rtl/cyc_timer.sv
module cyc_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/bit_sampler.sv
module bit_sampler #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [N-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[N-2:0], din};
        end
    end

endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int PWRUP_CYC = 300,
    parameter int CONV_CYC  = 1000,
    parameter int HALF_CYC  = 4,
    parameter int NBITS     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    output logic             ready_o,
    output logic             start_o,
    output logic             sclk_o,
    input  logic             sdata_i,
    output logic [NBITS-1:0] data_o,
    output logic             valid_o
);

    localparam int MAXC1 = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
    localparam int MAXC  = (MAXC1 > HALF_CYC) ? MAXC1 : HALF_CYC;
    localparam int TW    = $clog2(MAXC + 1);
    localparam int BW    = (NBITS > 2) ? $clog2(NBITS) : 1;

    localparam logic [TW-1:0] PWRUP_LD = TW'(PWRUP_CYC - 1);
    localparam logic [TW-1:0] CONV_LD  = TW'(CONV_CYC - 1);
    localparam logic [TW-1:0] HALF_LD  = TW'(HALF_CYC - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

    ctrl_state_t state_q, state_d;
    logic        t_load;
    logic [TW-1:0] t_val;
    logic        t_done;
    logic        shift_en;
    logic [BW-1:0] bit_q;
    logic        last_bit;

    assign last_bit = (bit_q == LAST_BIT);

    cyc_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_done)
    );

    bit_sampler #(.N(NBITS)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (sdata_i),
        .q        (data_o)
    );

    // state register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE) begin
                bit_q <= '0;
            end else if (shift_en) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        t_load   = 1'b0;
        t_val    = '0;
        shift_en = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_i) begin
                    state_d = S_POWERUP;
                    t_load  = 1'b1;
                    t_val   = PWRUP_LD;
                end
            end
            S_POWERUP: begin
                if (t_done) begin
                    state_d = S_CONVERT;
                    t_load  = 1'b1;
                    t_val   = CONV_LD;
                end
            end
            S_CONVERT: begin
                if (t_done) begin
                    state_d = S_CLK_HI;
                    t_load  = 1'b1;
                    t_val   = HALF_LD;
                end
            end
            S_CLK_HI: begin
                if (t_done) begin
                    shift_en = 1'b1;
                    if (last_bit) begin
                        state_d = S_DONE;
                    end else begin
                        state_d = S_CLK_LO;
                        t_load  = 1'b1;
                        t_val   = HALF_LD;
                    end
                end
            end
            S_CLK_LO: begin
                if (t_done) begin
                    state_d = S_CLK_HI;
                    t_load  = 1'b1;
                    t_val   = HALF_LD;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        ready_o = (state_q == S_IDLE);
        start_o = (state_q == S_POWERUP);
        sclk_o  = (state_q == S_CLK_HI);
        valid_o = (state_q == S_DONE);
    end

endmodule

// File: rtl/adc_sample_ctrl_chk.sv
module adc_sample_ctrl_chk #(
    parameter int NBITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready_o,
    input logic             start_o,
    input logic             sclk_o,
    input logic [NBITS-1:0] data_o,
    input logic             valid_o
);

    // R6
    start_rise_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_o) |-> $past(ready_o));

    // R8
    sclk_start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !start_o);

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> (!valid_o && ready_o));

    // R7
    valid_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !ready_o);

    // R5
    data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> $fell(sclk_o));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!start_o && !sclk_o && !valid_o));

endmodule

bind adc_sample_ctrl adc_sample_ctrl_chk #(.NBITS(NBITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_o (ready_o),
    .start_o (start_o),
    .sclk_o  (sclk_o),
    .data_o  (data_o),
    .valid_o (valid_o)
);

// File: tb/tb_adc_sample_ctrl.sv
module tb_adc_sample_ctrl;

    localparam int PWRUP = 300;
    localparam int CONV  = 1000;
    localparam int HALF  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       ready_o, start_o, sclk_o, valid_o;
    logic       sdata_i = 1'b0;
    logic [7:0] data_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_sample_ctrl #(.PWRUP_CYC(PWRUP), .CONV_CYC(CONV), .HALF_CYC(HALF), .NBITS(8)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ready_o(ready_o),
        .start_o(start_o), .sclk_o(sclk_o), .sdata_i(sdata_i),
        .data_o(data_o), .valid_o(valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // device model and protocol monitor
    logic [7:0] pending = 8'h00;
    logic [7:0] dev_res = 8'h5A;
    bit p_start = 0, p_sclk = 0, conv_run = 0, wait_first = 0, reading = 0;
    bit in_txn = 0, ready_bad = 0, after_valid = 0;
    int conv_cnt = 0, st_w = 0, gap = 0, hi_w = 0, lo_w = 0;
    int rises = 0, start_rises = 0, dev_idx = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (after_valid) begin
                // R7
                chk(!valid_o && ready_o, "R7 valid one cycle, ready back", int'(valid_o), 0);
                after_valid = 0;
            end
            if (conv_run) begin
                conv_cnt++;
                if (conv_cnt == CONV) begin
                    dev_res = pending;
                    conv_run = 0;
                end
            end
            if (wait_first) gap++;
            if (start_o && !p_start) begin
                start_rises++;
                st_w = 0;
                dev_idx = 0;
                in_txn = 1;
                // R6
                if (reading) chk(0, "R6 start rose during read", 1, 0);
            end
            if (start_o) st_w++;
            if (!start_o && p_start) begin
                // R2
                chk(st_w == PWRUP, "R2 power-up width", st_w, PWRUP);
                conv_run = 1;
                conv_cnt = 0;
                gap = 0;
                wait_first = 1;
            end
            if (sclk_o && !p_sclk) begin
                if (wait_first) begin
                    // R3
                    chk(gap == CONV, "R3 conversion wait", gap, CONV);
                    wait_first = 0;
                end else begin
                    // R4
                    chk(lo_w == HALF, "R4 low width", lo_w, HALF);
                end
                hi_w = 0;
                rises++;
                reading = 1;
                sdata_i = (dev_idx < 8) ? dev_res[7 - dev_idx] : 1'b0;
                dev_idx++;
            end
            if (sclk_o) hi_w++;
            if (!sclk_o && p_sclk) begin
                // R4
                chk(hi_w == HALF, "R4 high width", hi_w, HALF);
                lo_w = 0;
            end
            if (!sclk_o && reading) lo_w++;
            if (in_txn && ready_o) ready_bad = 1;
            if (valid_o) begin
                // R4
                chk(rises == 8, "R4 pulse count", rises, 8);
                // R5
                chk(data_o == pending, "R5 data byte", int'(data_o), int'(pending));
                // R8
                chk(!start_o, "R8 start low at valid", int'(start_o), 0);
                // R6
                chk(start_rises == 1, "R6 one start pulse", start_rises, 1);
                // R7
                chk(!ready_bad, "R7 ready low while busy", int'(ready_bad), 0);
                rises = 0; start_rises = 0; reading = 0; in_txn = 0; ready_bad = 0;
                after_valid = 1;
            end
            p_start = start_o;
            p_sclk = sclk_o;
        end
    end

    task automatic run_one(input logic [7:0] val, input int idle, input bit hold);
        pending = val;
        repeat (idle) @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        if (!hold) req_i = 1'b0;
        while (!valid_o) @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] directed(input int i);
        logic [7:0] v;
        case (i)
            0: v = 8'h00;
            1: v = 8'hFF;
            2: v = 8'h80;
            3: v = 8'h01;
            default: v = 8'hA5;
        endcase
        return v;
    endfunction

    initial begin
        int unsigned s;
        s = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        // R1
        chk(ready_o && !start_o && !sclk_o && !valid_o, "R1 reset state",
            int'({ready_o, start_o, sclk_o, valid_o}), 8);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5; i++) run_one(directed(i), 2, i[0]);
        for (int i = 0; i < 30; i++) begin
            run_one(8'($urandom), int'($urandom % 20), bit'($urandom % 2));
        end
        repeat (50) @(negedge clk);
        // R8
        chk(!start_o && !sclk_o && ready_o, "R8 asleep after idle gap", int'(start_o), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule